// File: doc/BRIEF.md
# Dynamic Port-Width Transfer Splitter

This block sits between a 32-bit processing core and an asynchronous external bus. The core hands it one operand of one to four bytes at any byte address. The block then runs as many bus cycles as that operand needs. On every cycle, the responding device's acknowledge states whether the port is 8, 16 or 32 bits wide. From that width and the low address bits, the block works out how many bytes the cycle actually moved. It then advances the address, lowers the remaining-byte count, and starts the next cycle until nothing is left.

For each cycle the block drives the address, a two-bit count of the bytes still owed, and all 32 write-data lines. The write lines carry copies of the operand bytes, so a port of any width finds its bytes on the lanes it is wired to. On reads, the block takes the bytes from the lanes the device used and assembles them into a right-justified operand. A one-cycle completion pulse ends the transfer. Caches, arbitration, bus errors and retries lie outside this block.

Top module: `xfer_splitter`

## Requirements
- R1: The size output and the request length share one 2-bit code for the byte count: 00 = four bytes, 01 = one, 10 = two, 11 = three. On every bus cycle the size output gives the number of operand bytes not yet moved.
- R2: A bus cycle ends at the first rising clock edge where the strobe is high and at least one acknowledge line (active low) is low. `bus_ack_n` = 2'b10 (bit 0 low alone) means an 8-bit port, 2'b01 means a 16-bit port, and 2'b00 means a 32-bit port. The port width is taken anew on every cycle. While the strobe is high and no acknowledge is seen, the address, size and write data stay steady.
- R3: Each acknowledged cycle moves min(remaining, W − (address mod W)) bytes, where W is the port width in bytes. The address advances by that amount and the remaining count drops by it. The number of bus cycles follows from this rule.
- R4: Lane 0 is D31–D24 and lane 3 is D7–D0. A port of width W at byte offset q takes its first byte on lane q. On writes, all 32 lines are driven so that an 8-, 16- or 32-bit port at the current address each finds the next operand bytes on its own lanes. The operand byte at the lowest address goes first.
- R5: On reads, the bytes of each cycle are taken from lanes q onward and placed in operand order. The result appears right-justified on `rdata`, with the byte at the lowest address as the most significant byte.
- R6: `busy` is high from the edge that accepts a request until the edge that raises `done`. `done` is high for exactly one cycle, in the cycle after the last acknowledged bus cycle, and `rdata` is valid from then on.
- R7: The strobe goes low for at least one clock after each acknowledged cycle before the next bus cycle begins.
- R8: After reset, the strobe, `busy` and `done` are low. An acknowledge while no cycle is running has no effect, and a request presented while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a transfer (taken only when idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the operand |
| req_len | input | 2 | Operand length, coded as in R1 |
| req_wdata | input | 32 | Write operand, right-justified |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Read operand, right-justified |
| bus_strobe | output | 1 | Bus cycle in progress |
| bus_rw | output | 1 | 1 = read cycle |
| bus_addr | output | ADDR_W | Address of the current bus cycle |
| bus_siz | output | 2 | Remaining-byte code (R1) |
| bus_dout | output | 32 | Lane-routed write data |
| bus_din | input | 32 | Read data from the device |
| bus_ack_n | input | 2 | Active-low acknowledge and port width |

## Verification
The assertions check, on every cycle, the behaviour that needs no knowledge of the operand. While a cycle waits, the address, size and data hold steady. The strobe drops after each acknowledge. `done` is a single pulse caused by an acknowledged cycle. No strobe appears while the block is idle. Each step stays between one and the remaining count. Only the bench's scenarios can show the arithmetic as a whole: the cycle count and size sequence for every width, length and offset, the lane copies every port width sees, the bytes that land in memory, and the read operand assembled across cycles. Further scenarios cover port widths that change from cycle to cycle, stray acknowledges, and requests made while busy.

// File: rtl/xs_pkg.sv
package xs_pkg;
  localparam int BYTE_W = 8;
  localparam int LANES  = 4;
  localparam int DATA_W = BYTE_W * LANES;
  localparam int CNT_W  = $clog2(LANES) + 1;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_GAP} xs_state_e;

  // byte-count code shared by request length and bus size output
  function automatic logic [CNT_W-1:0] count_of(input logic [1:0] code);
    return (code == 2'b00) ? CNT_W'(LANES) : {1'b0, code};
  endfunction
endpackage

// File: rtl/xs_step_calc.sv
module xs_step_calc
  import xs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic [1:0]       addr_lo,
  input  logic [CNT_W-1:0] remain,
  input  logic [1:0]       ack_n,
  output logic             ack_hit,
  output logic [CNT_W-1:0] step,
  output logic [1:0]       lane_base
);
  logic [CNT_W-1:0] port_bytes;
  logic [CNT_W-1:0] room;

  always_comb begin
    port_bytes = '0;
    lane_base  = 2'b00;
    unique case (ack_n)
      2'b10:   begin port_bytes = CNT_W'(1); lane_base = 2'b00; end
      2'b01:   begin port_bytes = CNT_W'(2); lane_base = {1'b0, addr_lo[0]}; end
      2'b00:   begin port_bytes = CNT_W'(4); lane_base = addr_lo; end
      default: begin port_bytes = '0;        lane_base = 2'b00; end
    endcase
    room    = port_bytes - {1'b0, lane_base};
    step    = (remain < room) ? remain : room;
    ack_hit = active && (ack_n != 2'b11);
  end

  AST_STEP_BOUNDS: assert property (@(posedge clk) disable iff (rst)
    ack_hit |-> (step != '0) && (step <= remain)); // R3
endmodule

// File: rtl/xs_lane_route.sv
module xs_lane_route
  import xs_pkg::*;
(
  input  logic [DATA_W-1:0] opnd_lj,
  input  logic [1:0]        offset,
  output logic [DATA_W-1:0] lanes
);
  logic [BYTE_W-1:0] b0, b1, b2, b3;

  always_comb begin
    b0 = opnd_lj[31:24];
    b1 = opnd_lj[23:16];
    b2 = opnd_lj[15:8];
    b3 = opnd_lj[7:0];
    unique case (offset)
      2'd0: lanes = {b0, b1, b2, b3};
      2'd1: lanes = {b0, b0, b1, b2};
      2'd2: lanes = {b0, b1, b0, b1};
      default: lanes = {b0, b0, b1, b0};
    endcase
  end
endmodule

// File: rtl/xs_read_gather.sv
module xs_read_gather
  import xs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              capture,
  input  logic [DATA_W-1:0] din,
  input  logic [1:0]        lane_base,
  input  logic [CNT_W-1:0]  step,
  input  logic [CNT_W-1:0]  pos_base,
  output logic [DATA_W-1:0] asm_next
);
  logic [DATA_W-1:0] asm_q;

  always_comb begin
    asm_next = asm_q;
    if (capture) begin
      for (int j = 0; j < LANES; j++) begin
        if ((j < int'(step)) && (int'(pos_base) + j < LANES) &&
            (int'(lane_base) + j < LANES)) begin
          asm_next[BYTE_W*(LANES-1-(int'(pos_base)+j)) +: BYTE_W] =
            din[BYTE_W*(LANES-1-(int'(lane_base)+j)) +: BYTE_W];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) asm_q <= '0;
    else              asm_q <= asm_next;
  end
endmodule

// File: rtl/xfer_splitter.sv
module xfer_splitter
  import xs_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_len,
  input  logic [31:0]       req_wdata,
  output logic              busy,
  output logic              done,
  output logic [31:0]       rdata,
  output logic              bus_strobe,
  output logic              bus_rw,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_siz,
  output logic [31:0]       bus_dout,
  input  logic [31:0]       bus_din,
  input  logic [1:0]        bus_ack_n
);
  xs_state_e         state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  rem_q, len_q;
  logic [DATA_W-1:0] opnd_q;
  logic              wr_q;

  logic              start, ack_hit;
  logic [CNT_W-1:0]  step, req_cnt, adv_rem;
  logic [1:0]        lane_base;
  logic [ADDR_W-1:0] adv_addr;
  logic [DATA_W-1:0] adv_opnd, req_lj, route_src, routed, asm_next;
  logic [1:0]        route_off;

  assign start    = (state_q == ST_IDLE) && req_valid;
  assign req_cnt  = count_of(req_len);
  assign req_lj   = req_wdata << {CNT_W'(LANES) - req_cnt, 3'b000};
  assign adv_addr = addr_q + ADDR_W'(step);
  assign adv_rem  = rem_q - step;
  assign adv_opnd = opnd_q << {step, 3'b000};
  assign route_src = start ? req_lj : adv_opnd;
  assign route_off = start ? req_addr[1:0] : adv_addr[1:0];

  xs_step_calc u_step (
    .clk       (clk),
    .rst       (rst),
    .active    (state_q == ST_RUN),
    .addr_lo   (addr_q[1:0]),
    .remain    (rem_q),
    .ack_n     (bus_ack_n),
    .ack_hit   (ack_hit),
    .step      (step),
    .lane_base (lane_base)
  );

  xs_lane_route u_route (
    .opnd_lj (route_src),
    .offset  (route_off),
    .lanes   (routed)
  );

  xs_read_gather u_gather (
    .clk       (clk),
    .rst       (rst),
    .clear     (start),
    .capture   (ack_hit && !wr_q),
    .din       (bus_din),
    .lane_base (lane_base),
    .step      (step),
    .pos_base  (len_q - rem_q),
    .asm_next  (asm_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      addr_q     <= '0;
      rem_q      <= '0;
      len_q      <= '0;
      opnd_q     <= '0;
      wr_q       <= 1'b0;
      busy       <= 1'b0;
      done       <= 1'b0;
      rdata      <= '0;
      bus_strobe <= 1'b0;
      bus_dout   <= '0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            addr_q     <= req_addr;
            rem_q      <= req_cnt;
            len_q      <= req_cnt;
            opnd_q     <= req_lj;
            wr_q       <= req_write;
            bus_dout   <= routed;
            bus_strobe <= 1'b1;
            busy       <= 1'b1;
            state_q    <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (ack_hit) begin
            bus_strobe <= 1'b0;
            if (adv_rem == '0) begin
              state_q <= ST_IDLE;
              busy    <= 1'b0;
              done    <= 1'b1;
              rem_q   <= '0;
              if (!wr_q) rdata <= asm_next >> {CNT_W'(LANES) - len_q, 3'b000};
            end else begin
              state_q  <= ST_GAP;
              addr_q   <= adv_addr;
              rem_q    <= adv_rem;
              opnd_q   <= adv_opnd;
              bus_dout <= routed;
            end
          end
        end
        default: begin
          bus_strobe <= 1'b1;
          state_q    <= ST_RUN;
        end
      endcase
    end
  end

  assign bus_rw   = !wr_q;
  assign bus_addr = addr_q;
  assign bus_siz  = rem_q[1:0];

  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (bus_strobe && bus_ack_n == 2'b11) |=>
      (bus_strobe && $stable(bus_addr) && $stable(bus_siz) && $stable(bus_dout))); // R2
  AST_GAP_LOW: assert property (@(posedge clk) disable iff (rst)
    (bus_strobe && bus_ack_n != 2'b11) |=> !bus_strobe); // R7
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(bus_strobe && bus_ack_n != 2'b11)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !bus_strobe); // R8
endmodule

// File: tb/sim_xfer_splitter.sv
module sim_xfer_splitter;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_write;
  logic [31:0] req_addr, req_wdata;
  logic [1:0]  req_len;
  logic        busy, done, bus_strobe, bus_rw;
  logic [31:0] rdata, bus_addr, bus_dout;
  logic [31:0] bus_din = '0;
  logic [1:0]  bus_siz;
  logic [1:0]  bus_ack_n = 2'b11;

  always #5 clk = ~clk;

  xfer_splitter u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rdata(rdata), .bus_strobe(bus_strobe),
    .bus_rw(bus_rw), .bus_addr(bus_addr), .bus_siz(bus_siz),
    .bus_dout(bus_dout), .bus_din(bus_din), .bus_ack_n(bus_ack_n)
  );

  int errors = 0, checks = 0, total_cyc = 0;
  logic [7:0] mem [0:15];
  logic [7:0] op_b [0:3];
  int  m_rem, m_sent, m_cyc, port_mode, wait_left, cur_w;
  logic [31:0] m_addr;
  bit  m_wr, spur = 0, acked = 0, armed = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int min2(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  // one acknowledged cycle of the modelled device
  task automatic serve();
    int a, q, n;
    logic [1:0] code;
    logic [31:0] d;
    a = int'(m_addr[3:0]);
    chk(bus_siz == ((m_rem == 4) ? 2'b00 : 2'(m_rem)), "R1 size code", 32'(bus_siz), 32'(m_rem));
    chk(bus_addr == m_addr, "R3 cycle address", bus_addr, m_addr);
    q = a % cur_w;
    n = min2(m_rem, cur_w - q);
    code = (cur_w == 1) ? 2'b10 : (cur_w == 2) ? 2'b01 : 2'b00;
    if (m_wr) begin
      for (int wi = 0; wi < 3; wi++) begin
        int w, qq, nn;
        w = 1 << wi; qq = a % w; nn = min2(m_rem, w - qq);
        for (int j = 0; j < nn; j++)
          chk(bus_dout[8*(3-(qq+j)) +: 8] == op_b[m_sent+j], "R4 lane copy",
              32'(bus_dout[8*(3-(qq+j)) +: 8]), 32'(op_b[m_sent+j]));
      end
      for (int j = 0; j < n; j++) mem[(a+j) & 15] = bus_dout[8*(3-(q+j)) +: 8];
    end else begin
      d = $urandom;
      for (int j = 0; j < n; j++) d[8*(3-(q+j)) +: 8] = mem[(a+j) & 15];
      bus_din = d;
    end
    bus_ack_n = code;
    acked = 1;
    m_rem -= n; m_sent += n; m_addr += 32'(n); m_cyc++;
  endtask

  always @(negedge clk) begin
    if (rst) begin
      bus_ack_n = 2'b11; acked = 0; armed = 0;
    end else if (acked) begin
      chk(!bus_strobe, "R7 strobe low after ack", 32'(bus_strobe), 0);
      bus_ack_n = 2'b11; acked = 0; armed = 0;
    end else if (!bus_strobe) begin
      bus_ack_n = spur ? 2'b00 : 2'b11; armed = 0;
    end else begin
      if (!armed) begin
        armed = 1;
        wait_left = $urandom_range(0, 2);
        cur_w = (port_mode == 0) ? (1 << $urandom_range(0, 2)) : port_mode;
      end
      if (wait_left > 0) begin wait_left--; bus_ack_n = 2'b11; end
      else serve();
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge clk) begin
    total_cyc++;
    if (total_cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=below 150000", total_cyc);
      summary();
      $finish;
    end
  end

  task automatic xfer(input bit wr, input int off, input int len, input int mode,
                      input bit poke);
    logic [31:0] a, wd, exp_rd;
    logic [7:0]  exp_mem [0:15];
    int exp_cyc, r, aa, t;
    bit mem_ok;
    a = 32'h104 + 32'(off);
    wd = $urandom;
    if (len < 4) wd = wd & ((32'h1 << (8*len)) - 1);
    for (int i = 0; i < 16; i++) begin
      mem[i] = 8'($urandom);
      exp_mem[i] = mem[i];
    end
    exp_rd = '0;
    for (int i = 0; i < len; i++) begin
      op_b[i] = wd[8*(len-1-i) +: 8];
      exp_rd = (exp_rd << 8) | 32'(mem[(int'(a[3:0])+i) & 15]);
      if (wr) exp_mem[(int'(a[3:0])+i) & 15] = op_b[i];
    end
    exp_cyc = 0; r = len; aa = off;
    if (mode != 0)
      while (r > 0) begin
        int n;
        n = min2(r, mode - (aa % mode));
        r -= n; aa += n; exp_cyc++;
      end
    m_rem = len; m_sent = 0; m_addr = a; m_cyc = 0; port_mode = mode; m_wr = wr;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_len = 2'(len); req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    chk(busy, "R6 busy after accept", 32'(busy), 1);
    if (poke) begin
      @(negedge clk);
      req_valid = 1; req_write = !wr; req_addr = 32'h10a; req_len = 2'b01; req_wdata = ~wd;
      @(negedge clk);
      req_valid = 0;
    end
    t = 0;
    while (!done && t < 300) begin @(negedge clk); t++; end
    chk(done, "R6 done arrives", 32'(done), 1);
    chk(m_rem == 0, "R3 all bytes moved", 32'(m_rem), 0);
    if (mode != 0) chk(m_cyc == exp_cyc, "R3 cycle count", 32'(m_cyc), 32'(exp_cyc));
    if (wr) begin
      mem_ok = 1;
      for (int i = 0; i < 16; i++) if (mem[i] !== exp_mem[i]) mem_ok = 0;
      chk(mem_ok, "R4 memory contents", 32'(mem_ok), 1);
    end else begin
      chk(rdata == exp_rd, "R5 read operand", rdata, exp_rd);
    end
    @(negedge clk);
    chk(!done, "R6 done lasts one cycle", 32'(done), 0);
    chk(!busy && !bus_strobe, "R8 idle after transfer", {busy, bus_strobe}, 0);
  endtask

  initial begin
    rst = 1; req_valid = 0; req_write = 0; req_addr = '0; req_len = '0; req_wdata = '0;
    repeat (4) @(negedge clk);
    chk(!bus_strobe && !busy && !done, "R8 reset state", {bus_strobe, busy, done}, 0);
    rst = 0;
    @(negedge clk);
    spur = 1;
    repeat (3) begin
      @(negedge clk);
      chk(!busy && !bus_strobe && !done, "R8 stray ack ignored", {busy, bus_strobe, done}, 0);
    end
    spur = 0;
    @(negedge clk);
    for (int wr = 0; wr < 2; wr++)
      for (int wi = 0; wi < 3; wi++)
        for (int len = 1; len <= 4; len++)
          for (int off = 0; off < 4; off++)
            xfer(bit'(wr), off, len, 1 << wi, 0);
    // R2: port width changes from cycle to cycle
    for (int k = 0; k < 24; k++)
      xfer(bit'($urandom_range(0, 1)), $urandom_range(0, 3), $urandom_range(1, 4), 0, 0);
    // R8: request while busy is ignored
    xfer(1, 1, 4, 1, 1);
    xfer(0, 1, 4, 1, 1);
    summary();
    $finish;
  end
endmodule